// File: doc/BRIEF.md
# Flash-to-memory DMA engine

The block copies a run of 32-bit words between a memory-mapped serial-flash window and system DRAM without processor involvement. Software programs a flash address, a DRAM address and an encoded byte count through a small register port. It enables the done interrupt and then writes the control register with the enable bit and a direction bit. The engine moves one word at a time over two word-wide request/acknowledge master ports, one per side. When the last word has landed it raises a completion flag and, if enabled, an interrupt.

The length register holds the byte count minus four, limited to a word-aligned field. Both address registers drop their two low bits, so every access is word aligned. Writing zero to the control register stops a running copy, and writing zero to the interrupt register clears the completion flag. While a copy is in progress, the length register reads back the count still to go, in the same minus-four encoding.

The sequencer has three states. `ST_IDLE` waits for a start, which is a control write that raises the enable bit while it is low. `ST_IDLE -> ST_FETCH` happens on start. `ST_FETCH -> ST_STORE` happens when the source port acknowledges a read. `ST_STORE -> ST_FETCH` happens when the destination port acknowledges a write and words remain. `ST_STORE -> ST_IDLE` happens on the acknowledge of the last word, which is completion. `ST_FETCH/ST_STORE -> ST_IDLE` happens on abort, which is a control write with bit 0 clear.

Top module: `fdma_engine`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and neither master port requests.
- R2: Register offsets are 0x08 interrupt, 0x80 control, 0x84 flash base, 0x88 DRAM base and 0x8C length. The base registers store their written value with bits [1:0] forced to zero and read that value back. Every master address has bits [1:0] equal to zero.
- R3: The length register keeps only bits [24:2] of the written value and reads back zero elsewhere. A copy moves (stored length + 4) bytes, which is stored/4 + 1 words, and leaves the following destination word untouched.
- R4: Control bit 1 selects the direction: 0 copies flash to DRAM and 1 copies DRAM to flash. Word i of the copy goes from source base + 4i to destination base + 4i.
- R5: At most one master port requests at a time. Each word is read from the source and acknowledged before its destination write is requested. A request holds its address until it is acknowledged.
- R6: In the cycle the last destination write is acknowledged, the completion flag (interrupt register bit 11) is set. The interrupt output is high exactly when bit 3 (interrupt enable), bit 11 and control bit 0 are all set.
- R7: A write to the interrupt register stores bit 3. The write clears bit 11 when the written bit 11 is zero.
- R8: Writing control with bit 0 clear during a copy stops it. From the next cycle no master request is made, and the completion flag stays clear.
- R9: During a copy, the length register reads (words remaining - 1) * 4. Writes to the base and length registers are ignored until the copy ends.
- R10: Raising control bit 0 from zero starts a copy and clears a stale completion flag. Writing bit 0 as one while it is already one starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Completion interrupt |
| fl_req | output | 1 | Flash-side request |
| fl_we | output | 1 | Flash-side write (1) or read (0) |
| fl_addr | output | 32 | Flash-side byte address |
| fl_wdata | output | 32 | Flash-side write data |
| fl_ack | input | 1 | Flash-side acknowledge, one cycle |
| fl_rdata | input | 32 | Flash-side read data, valid with ack |
| mem_req | output | 1 | DRAM-side request |
| mem_we | output | 1 | DRAM-side write (1) or read (0) |
| mem_addr | output | 32 | DRAM-side byte address |
| mem_wdata | output | 32 | DRAM-side write data |
| mem_ack | input | 1 | DRAM-side acknowledge, one cycle |
| mem_rdata | input | 32 | DRAM-side read data, valid with ack |

## Verification
The hardest situation to reach from the ports is an abort that lands in the middle of a copy, while a request is outstanding. The bench slows the memory models with a programmable acknowledge latency and starts a long copy. It writes zero to control after a fixed number of cycles and then watches both request lines. The same slow acknowledges hold the engine busy long enough to read the remaining-count encoding and to try the ignored writes to the address and length registers. A sweep over copy lengths, both directions, latencies and misaligned bases covers the word count and masking arithmetic.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    localparam logic [7:0] OFS_IRQ   = 8'h08;
    localparam logic [7:0] OFS_CTL   = 8'h80;
    localparam logic [7:0] OFS_FBASE = 8'h84;
    localparam logic [7:0] OFS_DBASE = 8'h88;
    localparam logic [7:0] OFS_LEN   = 8'h8C;

    localparam int IEN_BIT  = 3;
    localparam int DONE_BIT = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_HI = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         reg_addr,
    input  logic               reg_wen,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               busy,
    input  logic [LEN_HI-2:0]  rem_words,
    input  logic               done,
    output logic               ctl_en,
    output logic               ctl_dir,
    output logic [AW-1:0]      flash_base,
    output logic [AW-1:0]      dram_base,
    output logic [LEN_HI-2:0]  len_words,
    output logic               irq_en,
    output logic               irq_stat,
    output logic               start,
    output logic               start_dir,
    output logic               abort
);

    localparam int CW  = LEN_HI - 1;
    localparam int PAD = 32 - LEN_HI - 1;

    logic wr_ctl, wr_fb, wr_db, wr_len, wr_irq;
    logic [31:0] fb_ext, db_ext, len_ext;

    assign wr_ctl = reg_wen && (reg_addr == OFS_CTL);
    assign wr_fb  = reg_wen && (reg_addr == OFS_FBASE);
    assign wr_db  = reg_wen && (reg_addr == OFS_DBASE);
    assign wr_len = reg_wen && (reg_addr == OFS_LEN);
    assign wr_irq = reg_wen && (reg_addr == OFS_IRQ);

    assign start     = wr_ctl && reg_wdata[0] && !ctl_en;
    assign start_dir = reg_wdata[1];
    assign abort     = wr_ctl && !reg_wdata[0] && busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en     <= 1'b0;
            ctl_dir    <= 1'b0;
            flash_base <= '0;
            dram_base  <= '0;
            len_words  <= '0;
            irq_en     <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctl_en  <= reg_wdata[0];
                ctl_dir <= reg_wdata[1];
            end
            if (wr_fb && !busy)
                flash_base <= {reg_wdata[AW-1:2], 2'b00};
            if (wr_db && !busy)
                dram_base <= {reg_wdata[AW-1:2], 2'b00};
            if (wr_len && !busy)
                len_words <= reg_wdata[LEN_HI:2];
            if (wr_irq)
                irq_en <= reg_wdata[IEN_BIT];
        end
    end

    // completion flag: hardware set wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_stat <= 1'b0;
        else if (done)
            irq_stat <= 1'b1;
        else if (start)
            irq_stat <= 1'b0;
        else if (wr_irq)
            irq_stat <= irq_stat & reg_wdata[DONE_BIT];
    end

    always_comb begin
        fb_ext = '0;
        db_ext = '0;
        fb_ext[AW-1:0] = flash_base;
        db_ext[AW-1:0] = dram_base;
        len_ext = {{PAD{1'b0}}, (busy ? rem_words : len_words), 2'b00};
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTL:   reg_rdata = {30'd0, ctl_dir, ctl_en};
            OFS_FBASE: reg_rdata = fb_ext;
            OFS_DBASE: reg_rdata = db_ext;
            OFS_LEN:   reg_rdata = len_ext;
            OFS_IRQ: begin
                reg_rdata[IEN_BIT]  = irq_en;
                reg_rdata[DONE_BIT] = irq_stat;
            end
            default:   reg_rdata = '0;
        endcase
    end

    // R6: completion from the sequencer must land in the flag
    p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_stat);

    // R10: a fresh start clears any stale completion
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !irq_stat);

    // R9: programmed length is frozen while busy
    p_len_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_len) |=> $stable(len_words));

    // R8: an abort leaves the enable bit low
    p_abort_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !ctl_en);

    localparam int UNUSED_CW = CW;

endmodule

// File: rtl/fdma_seq.sv
module fdma_seq
    import fdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_HI = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic              abort,
    input  logic [AW-1:0]     flash_base,
    input  logic [AW-1:0]     dram_base,
    input  logic [LEN_HI-2:0] len_words,
    output logic              busy,
    output logic [LEN_HI-2:0] rem_words,
    output logic              done,
    output logic              fl_req,
    output logic              fl_we,
    output logic [AW-1:0]     fl_addr,
    output logic [31:0]       fl_wdata,
    input  logic              fl_ack,
    input  logic [31:0]       fl_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);

    localparam int CW = LEN_HI - 1;
    localparam logic [AW-1:0] STEP = AW'(4);
    localparam logic [CW-1:0] ONE  = CW'(1);

    seq_state_t state, nxt;
    logic [AW-1:0] src_ptr, dst_ptr;
    logic [CW-1:0] rem;
    logic          dir;
    logic [31:0]   data_q;
    logic          src_ack, dst_ack;
    logic [31:0]   src_data;
    logic          last;

    assign src_ack  = dir ? mem_ack   : fl_ack;
    assign dst_ack  = dir ? fl_ack    : mem_ack;
    assign src_data = dir ? mem_rdata : fl_rdata;
    assign last     = (rem == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_FETCH;
            ST_FETCH: begin
                if (abort)        nxt = ST_IDLE;
                else if (src_ack) nxt = ST_STORE;
            end
            ST_STORE: begin
                if (abort)        nxt = ST_IDLE;
                else if (dst_ack) nxt = last ? ST_IDLE : ST_FETCH;
            end
            default:              nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            rem     <= '0;
            dir     <= 1'b0;
            data_q  <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                dir     <= start_dir;
                src_ptr <= start_dir ? dram_base  : flash_base;
                dst_ptr <= start_dir ? flash_base : dram_base;
                rem     <= len_words;
            end
            if (state == ST_FETCH && src_ack && !abort)
                data_q <= src_data;
            if (state == ST_STORE && dst_ack && !abort && !last) begin
                src_ptr <= src_ptr + STEP;
                dst_ptr <= dst_ptr + STEP;
                rem     <= rem - ONE;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        rem_words = rem;
        done      = (state == ST_STORE) && dst_ack && last && !abort;
        fl_req    = ((state == ST_FETCH) && !dir) || ((state == ST_STORE) && dir);
        mem_req   = ((state == ST_FETCH) && dir)  || ((state == ST_STORE) && !dir);
        fl_we     = (state == ST_STORE);
        mem_we    = (state == ST_STORE);
        fl_addr   = dir ? dst_ptr : src_ptr;
        mem_addr  = dir ? src_ptr : dst_ptr;
        fl_wdata  = data_q;
        mem_wdata = data_q;
    end

    // R5: never both ports at once
    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_req && mem_req));

    // R5: a pending request keeps its address until acknowledged
    p_fl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack && !abort) |=> (fl_req && $stable(fl_addr)));
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));

    // R2: addresses stay word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req |-> fl_addr[1:0] == 2'b00) and (mem_req |-> mem_addr[1:0] == 2'b00));

    // R8: abort silences both ports next cycle
    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!fl_req && !mem_req));

    // R4: pointers advance one word after each non-final store
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE && dst_ack && !abort && !last) |=>
            (src_ptr == $past(src_ptr) + STEP));

endmodule

// File: rtl/fdma_engine.sv
module fdma_engine
    import fdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_HI = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    reg_addr,
    input  logic          reg_wen,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          fl_req,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [31:0]   fl_wdata,
    input  logic          fl_ack,
    input  logic [31:0]   fl_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);

    localparam int CW = LEN_HI - 1;

    logic          busy, done, start, start_dir, abort;
    logic          ctl_en, ctl_dir, irq_en, irq_stat;
    logic [CW-1:0] rem_words, len_words;
    logic [AW-1:0] flash_base, dram_base;

    fdma_regs #(.AW(AW), .LEN_HI(LEN_HI)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wen    (reg_wen),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .rem_words  (rem_words),
        .done       (done),
        .ctl_en     (ctl_en),
        .ctl_dir    (ctl_dir),
        .flash_base (flash_base),
        .dram_base  (dram_base),
        .len_words  (len_words),
        .irq_en     (irq_en),
        .irq_stat   (irq_stat),
        .start      (start),
        .start_dir  (start_dir),
        .abort      (abort)
    );

    fdma_seq #(.AW(AW), .LEN_HI(LEN_HI)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_dir  (start_dir),
        .abort      (abort),
        .flash_base (flash_base),
        .dram_base  (dram_base),
        .len_words  (len_words),
        .busy       (busy),
        .rem_words  (rem_words),
        .done       (done),
        .fl_req     (fl_req),
        .fl_we      (fl_we),
        .fl_addr    (fl_addr),
        .fl_wdata   (fl_wdata),
        .fl_ack     (fl_ack),
        .fl_rdata   (fl_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    assign irq = irq_en && irq_stat && ctl_en;

    // R6: interrupt only while the engine is enabled and the flag is set
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_stat && ctl_en));

    // R8: nothing runs while the enable bit is low after it has settled
    p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !start) |=> !busy);

    logic unused_dir;
    assign unused_dir = ctl_dir;

endmodule

// File: tb/test_fdma_engine.sv
module test_fdma_engine;

    localparam logic [7:0] A_IRQ = 8'h08, A_CTL = 8'h80, A_FB = 8'h84,
                           A_DB = 8'h88, A_LEN = 8'h8C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        fl_req, fl_we, fl_ack;
    logic [31:0] fl_addr, fl_wdata, fl_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    logic init_req = 1'b0;

    logic [31:0] fmem [256];
    logic [31:0] dmem [256];
    int fcnt, dcnt;

    always #10 clk = ~clk;

    fdma_engine i_fdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_ack(fl_ack), .fl_rdata(fl_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory models with programmable acknowledge latency
    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 256; i++) begin
                fmem[i] <= 32'hF000_0000 | i;
                dmem[i] <= 32'hD000_0000 | i;
            end
        end
        if (!rst_n) begin
            fl_ack <= 1'b0; fcnt <= 0; fl_rdata <= '0;
        end else if (fl_req && !fl_ack) begin
            if (fcnt >= lat) begin
                fl_ack <= 1'b1; fcnt <= 0;
                if (fl_we) fmem[fl_addr[9:2]] <= fl_wdata;
                else       fl_rdata <= fmem[fl_addr[9:2]];
            end else fcnt <= fcnt + 1;
        end else begin
            fl_ack <= 1'b0;
            if (!fl_req) fcnt <= 0;
        end
        if (!rst_n) begin
            mem_ack <= 1'b0; dcnt <= 0; mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            if (dcnt >= lat) begin
                mem_ack <= 1'b1; dcnt <= 0;
                if (mem_we) dmem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= dmem[mem_addr[9:2]];
            end else dcnt <= dcnt + 1;
        end else begin
            mem_ack <= 1'b0;
            if (!mem_req) dcnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic init_mem();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    task automatic wait_irq(output bit ok);
        int k = 0;
        while (!irq && k < 3000) begin
            @(negedge clk);
            k++;
        end
        ok = irq;
    endtask

    // check destination words and the sentinel after them
    task automatic check_copy(input bit dir, input logic [31:0] fb,
                              input logic [31:0] db, input int n, input string req);
        int s, d;
        logic [31:0] got, exp;
        s = dir ? int'(db[9:2]) : int'(fb[9:2]);
        d = dir ? int'(fb[9:2]) : int'(db[9:2]);
        for (int i = 0; i <= n; i++) begin
            got = dir ? fmem[d + i] : dmem[d + i];
            if (i < n) exp = (dir ? 32'hD000_0000 : 32'hF000_0000) | (s + i);
            else       exp = (dir ? 32'hF000_0000 : 32'hD000_0000) | (d + i);
            chk(got == exp, req, got, exp);
        end
    endtask

    task automatic run_copy(input bit dir, input logic [31:0] fb, input logic [31:0] db,
                            input int n, input int l, input bit ien);
        bit ok;
        logic [31:0] v;
        lat = l;
        init_mem();
        wr(A_CTL, 32'h0);
        wr(A_FB, fb);
        wr(A_DB, db);
        wr(A_LEN, 32'(n * 4 - 4));
        wr(A_IRQ, ien ? 32'h8 : 32'h0);
        wr(A_CTL, {30'd0, dir, 1'b1});
        if (ien) begin
            wait_irq(ok);
            chk(ok, "R6 irq on completion", {31'd0, irq}, 32'd1);
        end else begin
            repeat (n * (2 * l + 6) + 20) @(negedge clk);
            chk(irq == 1'b0, "R6 irq masked by enable", {31'd0, irq}, 32'd0);
        end
        rd(A_IRQ, v);
        chk(v[11] == 1'b1, "R6 completion flag", v, 32'h800);
        check_copy(dir, fb & ~32'h3, db & ~32'h3, n, "R4/R3 copy");
        wr(A_IRQ, 32'h0);
        rd(A_IRQ, v);
        chk(v == 32'h0 && irq == 1'b0, "R7 zero write clears flag", v, 32'h0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic main();
        logic [31:0] v;
        bit ok;
        int seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTL, v); chk(v == 0, "R1 ctl reset", v, 0);
        rd(A_FB, v);  chk(v == 0, "R1 flash base reset", v, 0);
        rd(A_DB, v);  chk(v == 0, "R1 dram base reset", v, 0);
        rd(A_LEN, v); chk(v == 0, "R1 length reset", v, 0);
        rd(A_IRQ, v); chk(v == 0, "R1 irq reg reset", v, 0);
        chk(!irq && !fl_req && !mem_req, "R1 outputs idle",
            {29'd0, irq, fl_req, mem_req}, 0);

        // R2 masking of base registers
        wr(A_FB, 32'h1234_5677);
        rd(A_FB, v); chk(v == 32'h1234_5674, "R2 flash base mask", v, 32'h1234_5674);
        wr(A_DB, 32'hABCD_EF01);
        rd(A_DB, v); chk(v == 32'hABCD_EF00, "R2 dram base mask", v, 32'hABCD_EF00);

        // R3 length field masking
        wr(A_LEN, 32'hFFFF_FFFF);
        rd(A_LEN, v); chk(v == 32'h01FF_FFFC, "R3 length mask", v, 32'h01FF_FFFC);

        // sweep: both directions, lengths, latencies, misaligned bases
        for (int dir = 0; dir < 2; dir++)
            for (int n = 1; n <= 8; n++)
                run_copy(dir[0], 32'(32'h40 + n * 8 + (n % 4)),
                         32'(32'h180 + n * 4 + ((n + 1) % 4)), n, n % 3, 1'b1);

        // R6 with interrupt enable low: flag set, irq stays low
        run_copy(1'b0, 32'h20, 32'h200, 3, 1, 1'b0);

        // R3 junk bits in the length write: 0xFE00000F stores 0x0C -> 4 words
        lat = 0;
        init_mem();
        wr(A_CTL, 0); wr(A_FB, 32'h10); wr(A_DB, 32'h300);
        wr(A_LEN, 32'hFE00_000F);
        rd(A_LEN, v); chk(v == 32'h0C, "R3 junk length stored", v, 32'h0C);
        wr(A_IRQ, 32'h8); wr(A_CTL, 32'h1);
        wait_irq(ok);
        chk(ok, "R3 junk length completes", {31'd0, ok}, 1);
        check_copy(1'b0, 32'h10, 32'h300, 4, "R3 four words moved");
        wr(A_IRQ, 0); wr(A_CTL, 0);

        // R9 remaining-count readback and ignored writes while busy
        lat = 3;
        init_mem();
        wr(A_FB, 32'h80); wr(A_DB, 32'h100); wr(A_LEN, 32'(20 * 4 - 4));
        wr(A_IRQ, 32'h8); wr(A_CTL, 32'h1);
        rd(A_LEN, v); chk(v == 32'd76, "R9 remaining at start", v, 32'd76);
        wr(A_FB, 32'h300);
        wr(A_LEN, 32'h4);
        repeat (30) @(negedge clk);
        rd(A_LEN, v); chk(v < 32'd76 && v[1:0] == 2'b00, "R9 remaining decreases", v, 32'd72);
        wait_irq(ok);
        chk(ok, "R9 copy completes", {31'd0, ok}, 1);
        rd(A_FB, v);  chk(v == 32'h80, "R9 base write ignored", v, 32'h80);
        rd(A_LEN, v); chk(v == 32'd76, "R9 length write ignored", v, 32'd76);
        check_copy(1'b0, 32'h80, 32'h100, 20, "R9 data intact");

        // R10 holding enable high does not restart
        wr(A_CTL, 32'h1);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (fl_req || mem_req) seen++;
        end
        chk(seen == 0, "R10 no restart on repeated enable", 32'(seen), 0);
        rd(A_IRQ, v); chk(v[11], "R10 flag kept", v, 32'h808);
        wr(A_CTL, 32'h0);
        chk(irq == 1'b0, "R6 irq gated by enable", {31'd0, irq}, 0);
        rd(A_IRQ, v); chk(v[11], "R6 flag survives idle disable", v, 32'h808);
        init_mem();
        wr(A_CTL, 32'h1);
        rd(A_IRQ, v); chk(!v[11], "R10 start clears stale flag", v, 32'h8);
        wait_irq(ok);
        chk(ok, "R10 restarted copy completes", {31'd0, ok}, 1);
        check_copy(1'b0, 32'h80, 32'h100, 20, "R10 restarted copy data");
        wr(A_IRQ, 0); wr(A_CTL, 0);

        // R8 abort mid-copy
        lat = 2;
        init_mem();
        wr(A_FB, 32'h0); wr(A_DB, 32'h200); wr(A_LEN, 32'(40 * 4 - 4));
        wr(A_IRQ, 32'h8); wr(A_CTL, 32'h1);
        repeat (30) @(negedge clk);
        wr(A_CTL, 32'h0);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (fl_req || mem_req) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R8 no requests after abort", 32'(seen), 0);
        rd(A_IRQ, v); chk(!v[11] && !irq, "R8 flag stays clear", v, 32'h8);
        chk(dmem[128] == 32'hF000_0000, "R8 first word copied", dmem[128], 32'hF000_0000);
        chk(dmem[128 + 39] == (32'hD000_0000 | 167), "R8 tail untouched",
            dmem[128 + 39], 32'hD000_0000 | 167);
        rd(A_LEN, v); chk(v == 32'd156, "R8 idle length readback", v, 32'd156);
    endtask

    initial begin
        bit wd = 1'b0;
        fork
            main();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule